// File: doc/BRIEF.md
# Ethernet receive address filter

This block decides, frame by frame, whether an incoming Ethernet frame is kept for the receive buffer. It watches the destination address as a byte-serial stream that follows a start-of-frame strobe. Each byte is compared on arrival with a programmable six-byte station address and with the all-ones broadcast pattern. When the end-of-frame strobe arrives with the CRC and alignment error flags, the block issues a one-cycle decision. The decision carries an accept bit and a match class (unicast, broadcast or other).

Software sets up the filter through a small register port. Offsets 0 to 5 hold the station address, and offset 0 is the byte compared with the first destination byte received. Offset 6 is a configuration byte. Bits 5:4 hold the acceptance mode. Bit 6 is a loopback enable that the filter stores but does not act on, because looped-back frames are judged by the same rules. Bit 7 keeps frames that carry receive errors. Every register reads back combinationally through the same address port. The values that drive filtering are snapshotted at each start of frame, so a write made during a frame changes nothing until the next frame.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, every register at offsets 0 to 6 reads 0x00 and decision_valid_o is low.
- R2: A write with cfg_we_i high stores cfg_wdata_i at cfg_addr_i (offsets 0 to 5 are station address bytes, offset 6 is the configuration byte), and cfg_rdata_o shows the stored byte of the register that cfg_addr_i selects.
- R3: decision_valid_o pulses high for exactly one cycle, in the cycle after eof_i is sampled, and only for a frame opened by sof_i. An eof_i with no open frame produces no decision.
- R4: match_class_o is 1 (unicast) when all six received bytes equal the station address, with the first byte compared against offset 0. It is 2 (broadcast) when all six bytes are 0xFF and the frame is not unicast. It is 0 (other) in every remaining case. Unicast takes priority over broadcast.
- R5: With configuration bits 5:4 equal to 0, no frame is accepted.
- R6: With mode 1, only unicast frames are accepted.
- R7: With mode 2, unicast and broadcast frames are accepted and other frames are discarded.
- R8: With mode 3, every complete frame is accepted, whatever its class.
- R9: A frame flagged with crc_err_i or align_err_i at eof_i is discarded unless configuration bit 7 is set, in which case the error has no effect on the decision.
- R10: A frame that ends with fewer than six address bytes is discarded with class 0, regardless of mode and bit 7.
- R11: Configuration and station address writes take effect at the next sof_i. A write in the same cycle as sof_i applies only from the frame after.
- R12: Configuration bit 6 (loopback) is stored and read back but does not change any decision.
- R13: When decision_valid_o is low, accept_o is low and match_class_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register offset for write and read |
| cfg_wdata_i | input | 8 | Register write data |
| cfg_rdata_o | output | 8 | Read data of the selected register |
| sof_i | input | 1 | Start-of-frame strobe |
| addr_valid_i | input | 1 | Destination address byte valid |
| addr_byte_i | input | 8 | Destination address byte |
| eof_i | input | 1 | End-of-frame strobe |
| crc_err_i | input | 1 | CRC error flag, valid with eof_i |
| align_err_i | input | 1 | Alignment error flag, valid with eof_i |
| decision_valid_o | output | 1 | One-cycle decision strobe |
| accept_o | output | 1 | Frame accepted, valid with the strobe |
| match_class_o | output | 2 | 0 other, 1 unicast, 2 broadcast |

## Verification
On every cycle, the assertions check the following: the decision pulse is one cycle wide and follows an end-of-frame, accept and class stay quiet between decisions, mode 0 never accepts, mode 1 accepts only unicast, modes 1 and 2 never accept an unmatched frame, and an errored frame is accepted only with the save bit set. Several behaviours can be shown only by the bench scenarios: the exact class reached from a given byte sequence, including byte order and unicast priority; discarding of truncated frames; register readback; the deferral of writes until the next start of frame; and the lack of any effect from the loopback bit.

// File: rtl/rx_addr_filter_pkg.sv
package rx_addr_filter_pkg;
  typedef enum logic [1:0] {
    MC_OTHER   = 2'd0,
    MC_UNICAST = 2'd1,
    MC_BCAST   = 2'd2
  } match_class_e;

  typedef enum logic [1:0] {
    AM_NONE    = 2'd0,
    AM_PHYS    = 2'd1,
    AM_PHYS_BC = 2'd2,
    AM_ALL     = 2'd3
  } accept_mode_e;

  localparam int unsigned CFG_MODE_LSB = 4;
  localparam int unsigned CFG_SAVE_BIT = 7;
endpackage

// File: rtl/rx_addr_filter_regs.sv
module rx_addr_filter_regs
  import rx_addr_filter_pkg::*;
#(
  parameter int unsigned N  = 6,
  parameter int unsigned W  = 8,
  parameter int unsigned AW = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [W-1:0]        wdata_i,
  output logic [W-1:0]        rdata_o,
  input  logic                sof_i,
  output logic [N-1:0][W-1:0] act_station_o,
  output accept_mode_e        act_mode_o,
  output logic                act_save_o
);
  localparam logic [AW-1:0] CFG_IDX = AW'(N);

  logic [N-1:0][W-1:0] station_q;
  logic [W-1:0]        cfg_q;

  for (genvar i = 0; i < N; i++) begin : g_station
    localparam logic [AW-1:0] IDX = AW'(i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    station_q[i] <= '0;
      else if (we_i && addr_i == IDX) station_q[i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cfg_q <= '0;
    else if (we_i && addr_i == CFG_IDX) cfg_q <= wdata_i;
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N; i++)
      if (addr_i == AW'(i)) rdata_o = station_q[i];
    if (addr_i == CFG_IDX) rdata_o = cfg_q;
  end

  // snapshot used by the filter; refreshed only at frame start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_station_o <= '0;
      act_mode_o    <= AM_NONE;
      act_save_o    <= 1'b0;
    end else if (sof_i) begin
      act_station_o <= station_q;
      act_mode_o    <= accept_mode_e'(cfg_q[CFG_MODE_LSB +: 2]);
      act_save_o    <= cfg_q[CFG_SAVE_BIT];
    end
  end
endmodule

// File: rtl/rx_addr_filter_cmp.sv
module rx_addr_filter_cmp #(
  parameter int unsigned N  = 6,
  parameter int unsigned W  = 8,
  parameter int unsigned CW = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sof_i,
  input  logic                eof_i,
  input  logic                valid_i,
  input  logic [W-1:0]        byte_i,
  input  logic [N-1:0][W-1:0] station_i,
  output logic                in_frame_o,
  output logic [CW-1:0]       cnt_nxt_o,
  output logic                uni_nxt_o,
  output logic                bc_nxt_o
);
  logic [CW-1:0] cnt_q;
  logic          uni_q, bc_q, in_frame_q;
  logic [W-1:0]  ref_byte;

  always_comb begin
    ref_byte = '0;
    for (int i = 0; i < N; i++)
      if (cnt_q == CW'(i)) ref_byte = station_i[i];
  end

  always_comb begin
    cnt_nxt_o = cnt_q;
    uni_nxt_o = uni_q;
    bc_nxt_o  = bc_q;
    if (valid_i && in_frame_q && cnt_q < CW'(N)) begin
      cnt_nxt_o = cnt_q + 1'b1;
      uni_nxt_o = uni_q & (byte_i == ref_byte);
      bc_nxt_o  = bc_q & (&byte_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      uni_q      <= 1'b0;
      bc_q       <= 1'b0;
      in_frame_q <= 1'b0;
    end else if (sof_i) begin
      cnt_q      <= '0;
      uni_q      <= 1'b1;
      bc_q       <= 1'b1;
      in_frame_q <= 1'b1;
    end else if (eof_i) begin
      in_frame_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt_o;
      uni_q <= uni_nxt_o;
      bc_q  <= bc_nxt_o;
    end
  end

  assign in_frame_o = in_frame_q;
endmodule

// File: rtl/rx_addr_filter_decide.sv
module rx_addr_filter_decide
  import rx_addr_filter_pkg::*;
#(
  parameter int unsigned N  = 6,
  parameter int unsigned CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          eof_i,
  input  logic          in_frame_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          uni_i,
  input  logic          bc_i,
  input  accept_mode_e  mode_i,
  input  logic          save_i,
  input  logic          crc_err_i,
  input  logic          align_err_i,
  output logic          valid_o,
  output logic          accept_o,
  output match_class_e  class_o
);
  logic         full, mode_ok, err_ok, fire;
  match_class_e cls;

  assign full   = (cnt_i == CW'(N));
  assign fire   = eof_i & in_frame_i;
  assign err_ok = save_i | ~(crc_err_i | align_err_i);

  always_comb begin
    if (!full)     cls = MC_OTHER;
    else if (uni_i) cls = MC_UNICAST;
    else if (bc_i)  cls = MC_BCAST;
    else            cls = MC_OTHER;
  end

  always_comb begin
    unique case (mode_i)
      AM_NONE:    mode_ok = 1'b0;
      AM_PHYS:    mode_ok = (cls == MC_UNICAST);
      AM_PHYS_BC: mode_ok = (cls != MC_OTHER);
      AM_ALL:     mode_ok = 1'b1;
      default:    mode_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      accept_o <= 1'b0;
      class_o  <= MC_OTHER;
    end else begin
      valid_o  <= fire;
      accept_o <= fire & full & mode_ok & err_ok;
      class_o  <= fire ? cls : MC_OTHER;
    end
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rx_addr_filter_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned BYTE_W     = 8,
  localparam int unsigned REG_AW    = $clog2(ADDR_BYTES + 1),
  localparam int unsigned CNT_W     = $clog2(ADDR_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [REG_AW-1:0] cfg_addr_i,
  input  logic [BYTE_W-1:0] cfg_wdata_i,
  output logic [BYTE_W-1:0] cfg_rdata_o,
  input  logic              sof_i,
  input  logic              addr_valid_i,
  input  logic [BYTE_W-1:0] addr_byte_i,
  input  logic              eof_i,
  input  logic              crc_err_i,
  input  logic              align_err_i,
  output logic              decision_valid_o,
  output logic              accept_o,
  output logic [1:0]        match_class_o
);
  logic [ADDR_BYTES-1:0][BYTE_W-1:0] act_station;
  accept_mode_e                      act_mode;
  logic                              act_save;
  logic                              in_frame, uni_nxt, bc_nxt;
  logic [CNT_W-1:0]                  cnt_nxt;
  match_class_e                      cls;

  rx_addr_filter_regs #(.N(ADDR_BYTES), .W(BYTE_W), .AW(REG_AW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i), .rdata_o(cfg_rdata_o),
    .sof_i,
    .act_station_o(act_station), .act_mode_o(act_mode), .act_save_o(act_save)
  );

  rx_addr_filter_cmp #(.N(ADDR_BYTES), .W(BYTE_W), .CW(CNT_W)) u_cmp (
    .clk_i, .rst_ni, .sof_i, .eof_i,
    .valid_i(addr_valid_i), .byte_i(addr_byte_i), .station_i(act_station),
    .in_frame_o(in_frame), .cnt_nxt_o(cnt_nxt), .uni_nxt_o(uni_nxt), .bc_nxt_o(bc_nxt)
  );

  rx_addr_filter_decide #(.N(ADDR_BYTES), .CW(CNT_W)) u_decide (
    .clk_i, .rst_ni, .eof_i,
    .in_frame_i(in_frame), .cnt_i(cnt_nxt), .uni_i(uni_nxt), .bc_i(bc_nxt),
    .mode_i(act_mode), .save_i(act_save),
    .crc_err_i, .align_err_i,
    .valid_o(decision_valid_o), .accept_o(accept_o), .class_o(cls)
  );

  assign match_class_o = cls;
endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk
  import rx_addr_filter_pkg::*;
(
  input logic         clk_i,
  input logic         rst_ni,
  input logic         eof_i,
  input logic         crc_err_i,
  input logic         align_err_i,
  input logic         decision_valid_o,
  input logic         accept_o,
  input logic [1:0]   match_class_o,
  input accept_mode_e act_mode,
  input logic         act_save
);
  // R3
  one_cycle_decision_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decision_valid_o |=> !decision_valid_o);
  // R3
  decision_after_eof_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decision_valid_o |-> $past(eof_i));
  // R13
  quiet_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !decision_valid_o |-> (!accept_o && match_class_o == 2'd0));
  // R5
  mode_none_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decision_valid_o && $past(act_mode) == AM_NONE) |-> !accept_o);
  // R6
  phys_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decision_valid_o && accept_o && $past(act_mode) == AM_PHYS) |-> match_class_o == 2'd1);
  // R7
  matched_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decision_valid_o && accept_o && $past(act_mode) != AM_ALL) |-> match_class_o != 2'd0);
  // R9
  err_discard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decision_valid_o && accept_o && !$past(act_save)) |-> !$past(crc_err_i || align_err_i));
endmodule

bind rx_addr_filter rx_addr_filter_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .eof_i(eof_i),
  .crc_err_i(crc_err_i), .align_err_i(align_err_i),
  .decision_valid_o(decision_valid_o), .accept_o(accept_o), .match_class_o(match_class_o),
  .act_mode(act_mode), .act_save(act_save)
);

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [2:0] waddr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       sof = 1'b0, valid = 1'b0, eof = 1'b0, crc = 1'b0, aln = 1'b0;
  logic [7:0] abyte = '0;
  logic       dv, acc;
  logic [1:0] cls;
  int         checks = 0, errors = 0;

  localparam logic [47:0] STA  = 48'h665544332211; // byte0 = 0x11 sent first
  localparam logic [47:0] BC   = 48'hFFFFFFFFFFFF;
  localparam logic [47:0] OTH  = 48'h0A0B0C0D0E0F;
  localparam logic [47:0] REV  = 48'h112233445566;

  always #2.5 clk = ~clk;

  rx_addr_filter u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(we), .cfg_addr_i(waddr), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata),
    .sof_i(sof), .addr_valid_i(valid), .addr_byte_i(abyte),
    .eof_i(eof), .crc_err_i(crc), .align_err_i(aln),
    .decision_valid_o(dv), .accept_o(acc), .match_class_o(cls)
  );

  function automatic logic [7:0] cfgv(input logic [1:0] mode, input logic loop, input logic save);
    return {save, loop, mode, 4'b0000};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; waddr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic set_station(input logic [47:0] sa);
    for (int i = 0; i < 6; i++) wr(3'(i), sa[8*i +: 8]);
  endtask

  // wr_at: -1 none, 0 with sof, k with address byte k
  task automatic run_frame(input logic [47:0] da, input int nb, input logic e_crc, input logic e_aln,
                           input int wr_at, input logic [7:0] wr_cfg,
                           input logic exp_acc, input logic [1:0] exp_cls, input string req);
    @(negedge clk); sof = 1'b1;
    if (wr_at == 0) begin we = 1'b1; waddr = 3'd6; wdata = wr_cfg; end
    @(negedge clk); sof = 1'b0; we = 1'b0;
    for (int i = 0; i < nb; i++) begin
      valid = 1'b1; abyte = da[8*i +: 8];
      if (wr_at == i + 1) begin we = 1'b1; waddr = 3'd6; wdata = wr_cfg; end
      @(negedge clk); we = 1'b0;
    end
    valid = 1'b0; eof = 1'b1; crc = e_crc; aln = e_aln;
    @(negedge clk); eof = 1'b0; crc = 1'b0; aln = 1'b0;
    chk({req, " strobe"}, 32'(dv), 32'd1);
    chk({req, " accept"}, 32'(acc), 32'(exp_acc));
    chk({req, " class"}, 32'(cls), 32'(exp_cls));
    @(negedge clk);
    chk("R3 pulse width", 32'(dv), 32'd0);
    chk("R13 idle outputs", 32'({acc, cls}), 32'd0);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 7; i++) begin
      waddr = 3'(i); #1;
      chk("R1 reset register", 32'(rdata), 32'd0);
    end
    chk("R1 no decision", 32'(dv), 32'd0);
  endtask

  task automatic t_readback;
    set_station(STA);
    wr(3'd6, 8'hA5);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); waddr = 3'(i); #1;
      chk("R2 station readback", 32'(rdata), 32'(STA[8*i +: 8]));
    end
    @(negedge clk); waddr = 3'd6; #1;
    chk("R2 config readback", 32'(rdata), 32'hA5);
  endtask

  task automatic t_eof_alone;
    @(negedge clk); eof = 1'b1;
    @(negedge clk); eof = 1'b0;
    chk("R3 eof without frame", 32'(dv), 32'd0);
  endtask

  task automatic t_modes;
    wr(3'd6, cfgv(2'd1, 1'b0, 1'b0));
    run_frame(STA, 6, 0, 0, -1, 0, 1'b1, 2'd1, "R6 R4 unicast");
    run_frame(OTH, 6, 0, 0, -1, 0, 1'b0, 2'd0, "R6 other");
    run_frame(BC,  6, 0, 0, -1, 0, 1'b0, 2'd2, "R6 broadcast");
    run_frame(REV, 6, 0, 0, -1, 0, 1'b0, 2'd0, "R4 byte order");
    wr(3'd6, cfgv(2'd2, 1'b0, 1'b0));
    run_frame(BC,  6, 0, 0, -1, 0, 1'b1, 2'd2, "R7 broadcast");
    run_frame(STA, 6, 0, 0, -1, 0, 1'b1, 2'd1, "R7 unicast");
    run_frame(OTH, 6, 0, 0, -1, 0, 1'b0, 2'd0, "R7 other");
    wr(3'd6, cfgv(2'd3, 1'b0, 1'b0));
    run_frame(OTH, 6, 0, 0, -1, 0, 1'b1, 2'd0, "R8 other");
    run_frame(BC,  6, 0, 0, -1, 0, 1'b1, 2'd2, "R8 broadcast");
    wr(3'd6, cfgv(2'd0, 1'b0, 1'b0));
    run_frame(STA, 6, 0, 0, -1, 0, 1'b0, 2'd1, "R5 unicast");
    run_frame(BC,  6, 0, 0, -1, 0, 1'b0, 2'd2, "R5 broadcast");
  endtask

  task automatic t_unicast_priority;
    set_station(BC);
    wr(3'd6, cfgv(2'd1, 1'b0, 1'b0));
    run_frame(BC, 6, 0, 0, -1, 0, 1'b1, 2'd1, "R4 unicast priority");
    set_station(STA);
  endtask

  task automatic t_errors;
    wr(3'd6, cfgv(2'd3, 1'b0, 1'b0));
    run_frame(STA, 6, 1, 0, -1, 0, 1'b0, 2'd1, "R9 crc dropped");
    run_frame(STA, 6, 0, 1, -1, 0, 1'b0, 2'd1, "R9 align dropped");
    wr(3'd6, cfgv(2'd3, 1'b0, 1'b1));
    run_frame(STA, 6, 1, 1, -1, 0, 1'b1, 2'd1, "R9 errors saved");
    wr(3'd6, cfgv(2'd1, 1'b0, 1'b1));
    run_frame(OTH, 6, 1, 0, -1, 0, 1'b0, 2'd0, "R9 saved but unmatched");
  endtask

  task automatic t_truncated;
    wr(3'd6, cfgv(2'd3, 1'b0, 1'b1));
    run_frame(STA, 4, 0, 0, -1, 0, 1'b0, 2'd0, "R10 four bytes");
    run_frame(STA, 0, 0, 0, -1, 0, 1'b0, 2'd0, "R10 no bytes");
  endtask

  task automatic t_deferred;
    wr(3'd6, cfgv(2'd1, 1'b0, 1'b0));
    run_frame(STA, 6, 0, 0, 3, cfgv(2'd0, 1'b0, 1'b0), 1'b1, 2'd1, "R11 mid-frame write");
    run_frame(STA, 6, 0, 0, -1, 0, 1'b0, 2'd1, "R11 next frame");
    run_frame(OTH, 6, 0, 0, 0, cfgv(2'd3, 1'b0, 1'b0), 1'b0, 2'd0, "R11 write with sof");
    run_frame(OTH, 6, 0, 0, -1, 0, 1'b1, 2'd0, "R11 frame after");
    // station change mid-frame keeps old address for this frame
    wr(3'd6, cfgv(2'd1, 1'b0, 1'b0));
    @(negedge clk); sof = 1'b1;
    @(negedge clk); sof = 1'b0;
    we = 1'b1; waddr = 3'd0; wdata = 8'h99;
    @(negedge clk); we = 1'b0;
    for (int i = 0; i < 6; i++) begin
      valid = 1'b1; abyte = STA[8*i +: 8];
      @(negedge clk);
    end
    valid = 1'b0; eof = 1'b1;
    @(negedge clk); eof = 1'b0;
    chk("R11 station write deferred", 32'({dv, acc, cls}), 32'b1101);
    wr(3'd0, STA[7:0]);
  endtask

  task automatic t_loopback;
    wr(3'd6, cfgv(2'd1, 1'b1, 1'b0));
    @(negedge clk); waddr = 3'd6; #1;
    chk("R12 loopback readback", 32'(rdata), 32'h50);
    run_frame(STA, 6, 0, 0, -1, 0, 1'b1, 2'd1, "R12 unicast");
    run_frame(BC,  6, 0, 0, -1, 0, 1'b0, 2'd2, "R12 broadcast");
    run_frame(STA, 6, 1, 0, -1, 0, 1'b0, 2'd1, "R12 error");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_readback();
    t_eof_alone();
    t_modes();
    t_unicast_priority();
    t_errors();
    t_truncated();
    t_deferred();
    t_loopback();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule